// File: doc/BRIEF.md
# Video-Memory SPI Dump Engine with Group Parity Retry

This block reads a fixed window of video memory and hands it, one byte at a time, to an SPI slave byte engine so that a debug host can pull a full image of the screen memory. Each byte is offered with a one-clock `tx_dv` strobe. The byte engine answers with `rx_dv` once the host has clocked that byte out. The host byte carried with a data byte is a dummy and is ignored.

After every eight data bytes the block offers a check byte: the XOR of those eight bytes. It then idles until the host sends a verdict byte. A verdict equal to the error code moves the read pointer back by one group, and the same eight bytes go out again with a fresh check byte. Any other verdict lets the stream carry on. The exchange that follows a verdict carries the next data byte, which the block fetches while the host clocks that exchange. The dump finishes after the last group of the window is acknowledged. The window is `WIN_END - WIN_START + 1` bytes (1024 by default). The read pointer is `ADDR_W` bits (11 by default). The end test also fires when the pointer wraps to zero, which covers a window that fills the pointer's whole range.

Top module: `vram_spi_dump`

## Requirements
- R1: While and just after `rst` is high, `busy`, `done`, `tx_dv` and `mem_rd_en` are all low.
- R2: A `start` pulse while idle clears the read pointer and the running check byte. The first byte, read from `WIN_START`, is offered with `tx_dv` on the second clock edge after the edge that samples `start`. A `start` while `busy` has no effect on the byte stream.
- R3: Data bytes go out in ascending address order from `WIN_START + pointer`, and each byte is offered with `tx_dv` high for exactly one clock.
- R4: After every eighth data byte the block offers a check byte equal to the bitwise XOR of those eight data bytes.
- R5: While waiting for a verdict, the block holds its state until `rx_dv` is high. During this wait it raises neither `tx_dv` nor `done`, whatever `rx_byte` holds.
- R6: A verdict equal to `ERR_CODE` (default 8'h22) moves the pointer back by 8, and the same group is offered again with its check byte rebuilt from zero.
- R7: Any verdict other than `ERR_CODE` acknowledges the group, and the next data byte follows it.
- R8: The dump ends when a verdict acknowledges the group that brings the pointer to the window size, or to zero by wrap-around. `done` then pulses for one clock, on the edge that samples that verdict, and `busy` drops.
- R9: After `rx_dv` for a data byte that does not end a group, or for an acknowledging verdict that does not end the dump, the next data byte's `tx_dv` comes on the second edge after. After `rx_dv` for the eighth byte of a group, the check byte's `tx_dv` comes on the first edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a dump (ignored while busy) |
| busy | output | 1 | A dump is in progress |
| done | output | 1 | One-clock pulse when the dump completes |
| mem_rd_en | output | 1 | Video-memory read request |
| mem_addr | output | MEM_AW | Video-memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one clock after `mem_rd_en` |
| tx_byte | output | DATA_W | Byte offered to the SPI byte engine |
| tx_dv | output | 1 | One-clock strobe: `tx_byte` is ready to send |
| rx_byte | input | DATA_W | Byte received from the host |
| rx_dv | input | 1 | Strobe: a byte exchange with the host has finished |

## Verification
Every result has a fixed delay from the `rx_dv` or `start` edge that causes it. The next data byte appears two edges later and the check byte one edge later. `done` rises on the very edge that samples the final verdict. The bench drives each strobe for exactly one clock between falling edges. It counts the falling edges until `tx_dv` appears and compares that count against these delays. It samples `done` at the falling edge that ends the verdict strobe. A second, narrow instance with a window equal to its pointer range runs in lockstep to show the wrap-around end.

// File: rtl/vdump_pkg.sv
package vdump_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_XFER,
    ST_PLOAD,
    ST_PXFER,
    ST_VERIFY
  } vdump_state_e;

endpackage

// File: rtl/vdump_addr_seq.sv
module vdump_addr_seq #(
  parameter int ADDR_W   = 11,
  parameter int GROUP    = 8,
  parameter int WIN_SIZE = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic              rewind,
  output logic [ADDR_W-1:0] addr,
  output logic              grp_end,
  output logic              win_end
);

  localparam int GRP_W = $clog2(GROUP);
  localparam logic [ADDR_W-1:0] STEP_BACK = ADDR_W'(GROUP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr <= '0;
    end else if (rewind) begin
      addr <= addr - STEP_BACK;
    end else if (inc) begin
      addr <= addr + 1'b1;
    end
  end

  assign grp_end = (addr[GRP_W-1:0] == '0);

  generate
    if (WIN_SIZE >= (1 << ADDR_W)) begin : g_wrap_only
      // Window fills the pointer range: completion is the roll-over to zero.
      assign win_end = (addr == '0);
    end else begin : g_sized
      localparam logic [ADDR_W-1:0] SIZE_T = ADDR_W'(WIN_SIZE);
      assign win_end = (addr == SIZE_T) || (addr == '0);
    end
  endgenerate

endmodule

// File: rtl/vdump_parity.sv
module vdump_parity #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              acc,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] par
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      par <= '0;
    end else if (acc) begin
      par <= par ^ din;
    end
  end

endmodule

// File: rtl/vdump_ctrl.sv
module vdump_ctrl
  import vdump_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         rx_dv,
  input  logic         rx_is_err,
  input  logic         grp_end,
  input  logic         win_end,
  output vdump_state_e state,
  output logic         cnt_clr,
  output logic         cnt_inc,
  output logic         cnt_rewind,
  output logic         par_clr,
  output logic         par_acc,
  output logic         load_data,
  output logic         load_par,
  output logic         finish
);

  vdump_state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= nxt;
    end
  end

  always_comb begin
    nxt        = state;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    cnt_rewind = 1'b0;
    par_clr    = 1'b0;
    par_acc    = 1'b0;
    load_data  = 1'b0;
    load_par   = 1'b0;
    finish     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          cnt_clr = 1'b1;
          par_clr = 1'b1;
          nxt     = ST_FETCH;
        end
      end
      ST_FETCH: nxt = ST_LOAD;
      ST_LOAD: begin
        load_data = 1'b1;
        par_acc   = 1'b1;
        cnt_inc   = 1'b1;
        nxt       = ST_XFER;
      end
      ST_XFER: begin
        if (rx_dv) nxt = grp_end ? ST_PLOAD : ST_FETCH;
      end
      ST_PLOAD: begin
        load_par = 1'b1;
        nxt      = ST_PXFER;
      end
      ST_PXFER: begin
        if (rx_dv) nxt = ST_VERIFY;
      end
      ST_VERIFY: begin
        if (rx_dv == 1'b1) begin
          par_clr = 1'b1;
          if (rx_is_err) begin
            cnt_rewind = 1'b1;
            nxt        = ST_FETCH;
          end else if (win_end) begin
            finish = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            nxt = ST_FETCH;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/vram_spi_dump.sv
module vram_spi_dump
  import vdump_pkg::*;
#(
  parameter int              MEM_AW    = 16,
  parameter logic [MEM_AW-1:0] WIN_START = 16'h0400,
  parameter logic [MEM_AW-1:0] WIN_END   = 16'h07FF,
  parameter int              ADDR_W    = 11,
  parameter int              GROUP     = 8,
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] ERR_CODE  = 8'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_dv,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_dv
);

  localparam int WIN_SIZE = int'(WIN_END) - int'(WIN_START) + 1;

  vdump_state_e      state;
  logic              cnt_clr, cnt_inc, cnt_rewind;
  logic              par_clr, par_acc, load_data, load_par, finish;
  logic              grp_end, win_end, rx_is_err, in_verify;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] par;
  logic [DATA_W-1:0] tx_byte_q;
  logic              tx_dv_q, done_q;

  assign rx_is_err = (rx_byte == ERR_CODE);

  vdump_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rx_dv      (rx_dv),
    .rx_is_err  (rx_is_err),
    .grp_end    (grp_end),
    .win_end    (win_end),
    .state      (state),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .cnt_rewind (cnt_rewind),
    .par_clr    (par_clr),
    .par_acc    (par_acc),
    .load_data  (load_data),
    .load_par   (load_par),
    .finish     (finish)
  );

  vdump_addr_seq #(
    .ADDR_W   (ADDR_W),
    .GROUP    (GROUP),
    .WIN_SIZE (WIN_SIZE)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .rewind  (cnt_rewind),
    .addr    (rd_addr),
    .grp_end (grp_end),
    .win_end (win_end)
  );

  vdump_parity #(
    .DATA_W (DATA_W)
  ) u_par (
    .clk (clk),
    .rst (rst),
    .clr (par_clr),
    .acc (par_acc),
    .din (mem_rd_data),
    .par (par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte_q <= '0;
      tx_dv_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (load_data) begin
        tx_byte_q <= mem_rd_data;
      end else if (load_par) begin
        tx_byte_q <= par;
      end
      tx_dv_q <= load_data | load_par;
      done_q  <= finish;
    end
  end

  assign in_verify = (state == ST_VERIFY);
  assign busy      = (state != ST_IDLE);
  assign mem_rd_en = (state == ST_FETCH);
  assign mem_addr  = WIN_START + MEM_AW'(rd_addr);
  assign tx_byte   = tx_byte_q;
  assign tx_dv     = tx_dv_q;
  assign done      = done_q;

endmodule

// File: rtl/vdump_checker.sv
module vdump_checker #(
  parameter int              ADDR_W   = 11,
  parameter int              GROUP    = 8,
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] ERR_CODE = 8'h22
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              tx_dv,
  input logic              rx_dv,
  input logic [DATA_W-1:0] rx_byte,
  input logic              in_verify,
  input logic [ADDR_W-1:0] addr
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !tx_dv && !mem_rd_en));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && addr == '0));

  assert_tx_single_R3: assert property (@(posedge clk) disable iff (rst)
    tx_dv |=> !tx_dv);

  assert_verify_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (in_verify && !rx_dv) |=> (in_verify && !tx_dv && !done));

  assert_rewind_group_R6: assert property (@(posedge clk) disable iff (rst)
    (in_verify && rx_dv && rx_byte == ERR_CODE) |=> (addr == $past(addr) - ADDR_W'(GROUP)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  assert_fetch_latency_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> ##2 tx_dv);

endmodule

bind vram_spi_dump vdump_checker #(
  .ADDR_W   (ADDR_W),
  .GROUP    (GROUP),
  .DATA_W   (DATA_W),
  .ERR_CODE (ERR_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_rd_en (mem_rd_en),
  .tx_dv     (tx_dv),
  .rx_dv     (rx_dv),
  .rx_byte   (rx_byte),
  .in_verify (in_verify),
  .addr      (rd_addr)
);

// File: tb/vram_spi_dump_test.sv
`timescale 1ns/1ps
module vram_spi_dump_test;

  localparam logic [15:0] WS   = 16'h0400;
  localparam logic [15:0] WE   = 16'h07FF;
  localparam int          WIN  = 1024;
  localparam logic [7:0]  ERRC = 8'h22;

  // {verdict byte, expect resend}
  localparam logic [8:0] VEC [8] = '{
    {8'h00, 1'b0}, {8'h22, 1'b1}, {8'h5A, 1'b0}, {8'h22, 1'b1},
    {8'h22, 1'b1}, {8'hFF, 1'b0}, {8'h21, 1'b0}, {8'h23, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rx_dv = 1'b0;
  logic [7:0] rx_byte = 8'h00;

  logic busy, done, rd_en, tx_dv;
  logic [15:0] maddr;
  logic [7:0] rd_data = 8'h00, tx_byte;
  logic busy_w, done_w, rd_en_w, tx_dv_w;
  logic [15:0] maddr_w;
  logic [7:0] rd_data_w = 8'h00, tx_byte_w;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5C;
  endfunction

  always @(posedge clk) begin
    if (rd_en) rd_data <= memf(maddr);
    if (rd_en_w) rd_data_w <= memf(maddr_w);
  end

  vram_spi_dump #(.WIN_START(WS), .WIN_END(WE), .ERR_CODE(ERRC)) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_rd_en(rd_en), .mem_addr(maddr), .mem_rd_data(rd_data),
    .tx_byte(tx_byte), .tx_dv(tx_dv), .rx_byte(rx_byte), .rx_dv(rx_dv));

  // Window of 32 bytes with a 5-bit pointer: ends by wrap-around.
  vram_spi_dump #(.WIN_START(16'h0100), .WIN_END(16'h011F), .ADDR_W(5), .ERR_CODE(ERRC)) uut_w (
    .clk(clk), .rst(rst), .start(start), .busy(busy_w), .done(done_w),
    .mem_rd_en(rd_en_w), .mem_addr(maddr_w), .mem_rd_data(rd_data_w),
    .tx_byte(tx_byte_w), .tx_dv(tx_dv_w), .rx_byte(rx_byte), .rx_dv(rx_dv));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "R8 watchdog", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_rx(input logic [7:0] v);
    rx_byte = v;
    rx_dv = 1'b1;
    @(negedge clk);
    rx_dv = 1'b0;
    rx_byte = 8'h00;
  endtask

  task automatic take_byte(input string req, input int lat, output logic [7:0] b);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tx_dv && n < 60);
    check(tx_dv, req, tx_dv, 1);
    check(n == lat, "R9", n, lat);
    b = tx_byte;
    @(negedge clk);
    check(!tx_dv, "R3", tx_dv, 0);
    pulse_rx(8'hA5);
  endtask

  initial begin
    logic [7:0] b, par;
    int exp_addr, vi, acked;
    bit resend, last_retry, bad;
    logic [7:0] v;
    string tag;

    repeat (3) @(negedge clk);
    check(!busy && !done && !tx_dv && !rd_en, "R1", {busy, done, tx_dv, rd_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    exp_addr = 0; vi = 0; acked = 0; last_retry = 1'b0;
    while (exp_addr < WIN) begin
      par = 8'h00;
      tag = (vi == 0) ? "R2" : (last_retry ? "R6" : "R7");
      for (int i = 0; i < 8; i++) begin
        take_byte(tag, 2, b);
        check(b == memf(WS + 16'(exp_addr + i)), tag, b, memf(WS + 16'(exp_addr + i)));
        par = par ^ memf(WS + 16'(exp_addr + i));
        tag = "R3";
      end
      take_byte("R4", 1, b);
      check(b == par, "R4", b, par);
      if (vi == 0) begin
        // Verdict wait: error code parked on rx_byte without strobe, plus a stray start.
        bad = 1'b0;
        rx_byte = ERRC;
        for (int k = 0; k < 12; k++) begin
          start = (k == 5);
          @(negedge clk);
          if (tx_dv || done || !busy) bad = 1'b1;
        end
        start = 1'b0;
        rx_byte = 8'h00;
        check(!bad, "R5", bad, 0);
      end
      resend = (vi < 8) ? VEC[vi][0] : 1'b0;
      v = (vi < 8) ? VEC[vi][8:1] : 8'h00;
      vi++;
      pulse_rx(v);
      if (!resend) begin
        exp_addr += 8;
        acked++;
      end
      last_retry = resend;
      check(done == (exp_addr == WIN), "R8", done, exp_addr == WIN);
      check(done_w == (!resend && acked == 4), "R8 wrap", done_w, !resend && acked == 4);
    end

    @(negedge clk);
    check(!busy && !done, "R8", {busy, done}, 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    take_byte("R2", 2, b);
    check(b == memf(WS), "R2", b, memf(WS));
    take_byte("R3", 2, b);
    check(b == memf(WS + 16'd1), "R3", b, memf(WS + 16'd1));

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !done && !tx_dv && !rd_en, "R1", {busy, done, tx_dv, rd_en}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule